// File: doc/BRIEF.md
# E1 Receive Error Counter Bank

This block keeps the one-second performance counts of an E1 receive framer. It counts three kinds of event, each arriving as a single-cycle strobe: errored frame alignment words, CRC4 block errors and E-bit indications. On every one-second tick the three running counts are captured into a readable snapshot, and the running counts restart from zero.

The alignment-word counter is 12 bits wide. It pauses while the receiver reports loss of signal, and while the framer is still searching for alignment or multiframe synchronization. Within one second the alignment-word count cannot exceed 4000, so it never wraps. The CRC4 and E-bit counters are 10 bits wide and have no such bound, so each stops at its all-ones value.

The snapshot is read through a byte-wide, combinational read port. Some bytes hold fields from two different counters.

Top module: `e1_err_counter_bank`

## Requirements
- R1: Each `fas_err` strobe accepted while `los` and `sync_search` are both low adds one to the 12-bit alignment-word count. A count of 4000 in one period is reported exactly.
- R2: `fas_err` strobes that arrive while `los` is high are not counted.
- R3: `fas_err` strobes that arrive while `sync_search` is high are not counted.
- R4: In a cycle with `sec_tick` high, the running counts are copied to the snapshot and the running counts restart. A strobe in that same cycle counts as 1 in the new period and does not appear in the snapshot being taken.
- R5: The 10-bit CRC4 count stops at 1023 and stays there when further `crc_err` strobes arrive.
- R6: The 10-bit E-bit count stops at 1023 and stays there when further `ebit_err` strobes arrive.
- R7: CRC4 and E-bit strobes are counted whatever the state of `los` and `sync_search`.
- R8: Address 0x02 reads alignment-word count bits 11..6 on data bits 7..2, and CRC4 count bits 9..8 on data bits 1..0.
- R9: Address 0x04 reads alignment-word count bits 5..0 on data bits 7..2, and E-bit count bits 9..8 on data bits 1..0.
- R10: Address 0x03 reads CRC4 count bits 7..0, and address 0x05 reads E-bit count bits 7..0, with the MSB on data bit 7.
- R11: A read at any other address returns 0x00.
- R12: After reset, every count and every snapshot field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fas_err | input | 1 | Errored alignment word strobe |
| crc_err | input | 1 | CRC4 block error strobe |
| ebit_err | input | 1 | E-bit indication strobe |
| los | input | 1 | Receive loss-of-signal status |
| sync_search | input | 1 | Framer is searching for alignment or multiframe sync |
| sec_tick | input | 1 | One-second snapshot strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational) |

## Verification
The bench builds the block with the default 8-bit address width. At that width the highest address, 0xFF, can be driven to confirm that unmapped reads return zero. The counter widths are fixed by the register layout, so a period of a few thousand strobes is enough to reach 4000 alignment errors and both 10-bit saturation points in one run. Loaded bit patterns are chosen so that every shared byte shows two different non-zero fields at once.

// File: rtl/e1_err_counter_bank.sv
module e1_err_counter_bank #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fas_err,
  input  logic              crc_err,
  input  logic              ebit_err,
  input  logic              los,
  input  logic              sync_search,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int FAS_W = 12;
  localparam int CRC_W = 10;
  localparam int EB_W  = 10;
  localparam logic [ADDR_W-1:0] A_FAS_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CRC_LO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FAS_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EB_LO  = ADDR_W'(5);

  logic [FAS_W-1:0] fas_cnt, fas_snap;
  logic [CRC_W-1:0] crc_cnt, crc_snap;
  logic [EB_W-1:0]  eb_cnt,  eb_snap;

  wire fas_ok = fas_err && !los && !sync_search;
  wire crc_up = crc_err && !(&crc_cnt);
  wire eb_up  = ebit_err && !(&eb_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fas_cnt  <= '0;
      crc_cnt  <= '0;
      eb_cnt   <= '0;
      fas_snap <= '0;
      crc_snap <= '0;
      eb_snap  <= '0;
    end else if (sec_tick) begin
      fas_snap <= fas_cnt;
      crc_snap <= crc_cnt;
      eb_snap  <= eb_cnt;
      fas_cnt  <= FAS_W'(fas_ok);
      crc_cnt  <= CRC_W'(crc_err);
      eb_cnt   <= EB_W'(ebit_err);
    end else begin
      if (fas_ok) fas_cnt <= fas_cnt + 1'b1;
      if (crc_up) crc_cnt <= crc_cnt + 1'b1;
      if (eb_up)  eb_cnt  <= eb_cnt + 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_FAS_HI: rd_data = {fas_snap[11:6], crc_snap[9:8]};
      A_CRC_LO: rd_data = crc_snap[7:0];
      A_FAS_LO: rd_data = {fas_snap[5:0], eb_snap[9:8]};
      A_EB_LO:  rd_data = eb_snap[7:0];
      default:  rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/e1_err_counter_bank_chk.sv
module e1_err_counter_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fas_err,
  input logic              crc_err,
  input logic              los,
  input logic              sync_search,
  input logic              sec_tick,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [11:0]       fas_cnt,
  input logic [11:0]       fas_snap,
  input logic [9:0]        crc_cnt
);
  // R2 and R3: the alignment-word count holds while gated
  a_r2_r3_fas_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && (los || sync_search)) |=> fas_cnt == $past(fas_cnt));

  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> fas_snap == $past(fas_cnt));

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !crc_err) |=> crc_cnt == 10'd0);

  a_r5_crc_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && &crc_cnt) |=> &crc_cnt);

  a_r1_fas_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && fas_err && !los && !sync_search) |=> fas_cnt == $past(fas_cnt) + 12'd1);

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < ADDR_W'(2) || rd_addr > ADDR_W'(5)) |-> rd_data == 8'h00);
endmodule

bind e1_err_counter_bank e1_err_counter_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fas_err(fas_err), .crc_err(crc_err),
  .los(los), .sync_search(sync_search), .sec_tick(sec_tick),
  .rd_addr(rd_addr), .rd_data(rd_data),
  .fas_cnt(fas_cnt), .fas_snap(fas_snap), .crc_cnt(crc_cnt)
);

// File: tb/test_e1_err_counter_bank.sv
`timescale 1ns/100ps
module test_e1_err_counter_bank;
  logic clk = 0, rst_n = 0;
  logic fas_err = 0, crc_err = 0, ebit_err = 0, los = 0, sync_search = 0, sec_tick = 0;
  logic [7:0] rd_addr = 0;
  logic [7:0] rd_data;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  e1_err_counter_bank #(.ADDR_W(8)) i_e1_err_counter_bank (
    .clk(clk), .rst_n(rst_n), .fas_err(fas_err), .crc_err(crc_err),
    .ebit_err(ebit_err), .los(los), .sync_search(sync_search),
    .sec_tick(sec_tick), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    n_tests++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr 0x%02h: actual 0x%02h expected 0x%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_all(input logic [11:0] f, input logic [9:0] c, input logic [9:0] e, input string req);
    rd_chk(8'h02, {f[11:6], c[9:8]}, {req, " R8"});
    rd_chk(8'h03, c[7:0], {req, " R10"});
    rd_chk(8'h04, {f[5:0], e[9:8]}, {req, " R9"});
    rd_chk(8'h05, e[7:0], {req, " R10"});
  endtask

  task automatic run(input int nf, input int nc, input int ne, input bit l, input bit s);
    int m = nf > nc ? nf : nc;
    if (ne > m) m = ne;
    @(negedge clk);
    los = l; sync_search = s;
    for (int i = 0; i < m; i++) begin
      fas_err = (i < nf); crc_err = (i < nc); ebit_err = (i < ne);
      @(negedge clk);
    end
    fas_err = 0; crc_err = 0; ebit_err = 0; los = 0; sync_search = 0;
  endtask

  task automatic tick(input bit f, input bit c);
    @(negedge clk);
    sec_tick = 1; fas_err = f; crc_err = c;
    @(negedge clk);
    sec_tick = 0; fas_err = 0; crc_err = 0;
    #1;
  endtask

  task automatic t_reset;
    chk_all(12'd0, 10'd0, 10'd0, "R12");
    rd_chk(8'h00, 8'h00, "R11 R12");
  endtask

  task automatic t_basic;
    run(37, 0, 0, 0, 0);
    tick(0, 0);
    chk_all(12'd37, 10'd0, 10'd0, "R1");
  endtask

  task automatic t_gating;
    run(10, 7, 0, 1, 0);
    run(10, 0, 3, 0, 1);
    run(5, 0, 0, 0, 0);
    tick(0, 0);
    chk_all(12'd5, 10'd7, 10'd3, "R2 R3 R7");
  endtask

  task automatic t_pattern;
    run(12'hABC, 10'h2A5, 10'h15B, 0, 0);
    tick(0, 0);
    chk_all(12'hABC, 10'h2A5, 10'h15B, "R1");
    rd_chk(8'h00, 8'h00, "R11");
    rd_chk(8'h01, 8'h00, "R11");
    rd_chk(8'h06, 8'h00, "R11");
    rd_chk(8'hFF, 8'h00, "R11");
  endtask

  task automatic t_saturate;
    run(4000, 1030, 1030, 0, 0);
    tick(0, 0);
    chk_all(12'd4000, 10'd1023, 10'd1023, "R1 R5 R6");
  endtask

  task automatic t_tick_edge;
    run(4, 0, 0, 0, 0);
    tick(1, 1);
    chk_all(12'd4, 10'd0, 10'd0, "R4");
    tick(0, 0);
    chk_all(12'd1, 10'd1, 10'd0, "R4");
    tick(0, 0);
    chk_all(12'd0, 10'd0, 10'd0, "R4");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_basic();
    t_gating();
    t_pattern();
    t_saturate();
    t_tick_edge();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule